// File: doc/BRIEF.md
# PHY Management Register File

This block holds the standard management register set of an Ethernet PHY behind a plain register access port: a 5-bit address, 16-bit write data with a write strobe, and a read strobe with combinational read data. It implements the control word (address 0), the status word (address 1), the two identifier halves (addresses 2 and 3) and the gigabit extended status word (address 15). Every other address reads as zero. Serial management framing, the line side analog path and the negotiation algorithm live outside the block. The block only takes the negotiation outcome and the link state as inputs.

From the control word the block decodes the operating mode. It produces the effective speed and duplex, loopback, power down and isolate, a one-cycle negotiation restart pulse, and a transmit permission. It also steers a byte-wide data path: MAC transmit data goes to the line side, or is turned back onto the MAC receive side in loopback, and everything is silenced in power down. A software reset runs for a parameterised number of cycles. During that time the reset bit reads as set and writes are blocked. When it ends, the control fields and the status latch return to their defaults.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After the hardware reset, address 0 reads 0x1000 (only negotiation enable, bit 12, is set), `speed_mode` is 0, `full_duplex` is 0 and `an_restart` is 0.
- R2: Writing address 0 with bit 15 set starts a soft reset that lasts RST_CYCLES cycles. While it runs, bit 15 reads 1 and the other control bits keep their earlier value. Afterwards bit 15 reads 0 and the control word is back at 0x1000.
- R3: A write to address 0 while a soft reset runs changes no control bit.
- R4: With bit 12 clear, `speed_mode` follows the code {bit 6, bit 13}: 0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s. Code 3 keeps the previous speed. `full_duplex` follows bit 8. With bit 12 set, both follow `an_speed` (where code 3 also keeps the previous speed) and `an_full_duplex`. `speed_mode` changes one cycle after the control word.
- R5: Writing bit 9 = 1 together with bit 12 = 1 raises `an_restart` for exactly one cycle, and bit 9 reads 1 for that cycle only. If bit 12 is 0 in the same write, bit 9 stays 0 and no pulse is given.
- R6: `tx_allow` is 1 when power down is off and either `link_up` is 1 or bit 5 is in effect. Bit 5 is in effect only when bit 12 = 0 and bit 8 = 1.
- R7: With bit 14 set and power down off, `mac_rxd`/`mac_rx_dv` carry `mac_txd`/`mac_tx_en`, and `line_tx_en` and `line_txd` are 0. With bit 14 clear, `line_txd` = `mac_txd`, `line_tx_en` = `mac_tx_en` AND `tx_allow`, and `mac_rxd`/`mac_rx_dv` carry the line receive inputs.
- R8: Bit 11 (power down) forces `line_txd`, `line_tx_en`, `mac_rxd`, `mac_rx_dv` and `tx_allow` to 0. Bit 10 drives the `isolate` output.
- R9: Control bits 4:0 ignore writes and always read 0.
- R10: Status reads {CAPS[6:0] in bits 15:9, 1 in bit 8, UNIDIR_ABLE in bit 7, 0 in bit 6, `an_done` AND bit 12 in bit 5, 0 in bit 4, 1 in bit 3, latched link in bit 2, 0 in bit 1, 1 in bit 0}. With the defaults, the link up and negotiation done, this is 0x79AD.
- R11: Address 2 reads PHY_ID[31:16] and address 3 reads PHY_ID[15:0]. Address 15 reads {GIG_CAPS, 12'h000}, which is 0x3000 by default.
- R12: Status bit 2 latches low. Any cycle with `link_up` = 0 clears it. It then stays 0 through the next read of address 1, and after that read it follows `link_up` again.
- R13: Any address other than 0, 1, 2, 3 and 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; marks a read for the link latch |
| rd_data | output | 16 | Read data for `reg_addr` (combinational) |
| link_up | input | 1 | Live link indication |
| an_done | input | 1 | Negotiation complete |
| an_speed | input | 2 | Negotiated speed code |
| an_full_duplex | input | 1 | Negotiated duplex |
| mac_txd | input | DW | Transmit data from the MAC |
| mac_tx_en | input | 1 | Transmit valid from the MAC |
| line_rxd | input | DW | Receive data from the line side |
| line_rx_dv | input | 1 | Receive valid from the line side |
| line_txd | output | DW | Transmit data toward the line side |
| line_tx_en | output | 1 | Transmit valid toward the line side |
| mac_rxd | output | DW | Receive data toward the MAC |
| mac_rx_dv | output | 1 | Receive valid toward the MAC |
| speed_mode | output | 2 | Effective speed code |
| full_duplex | output | 1 | Effective duplex |
| loopback | output | 1 | Loopback mode active |
| power_down | output | 1 | Power down mode active |
| isolate | output | 1 | Isolate mode active |
| an_restart | output | 1 | Negotiation restart pulse |
| tx_allow | output | 1 | Transmit permission |

## Verification
On every cycle the assertions check the following:
- reserved control bits, the low bits of the extended status word and unimplemented addresses read zero;
- the restart pulse never lasts two cycles;
- power down silences both data directions;
- loopback keeps the line transmit side quiet.

Only the directed scenarios can show the behaviours that depend on history:
- the timed soft reset and the discarding of writes while it runs;
- the speed code that holds its value on the reserved code;
- the gating of the unidirectional bit;
- the read-to-clear link latch.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam logic [4:0] ADDR_CTRL  = 5'd0;
    localparam logic [4:0] ADDR_STAT  = 5'd1;
    localparam logic [4:0] ADDR_ID_HI = 5'd2;
    localparam logic [4:0] ADDR_ID_LO = 5'd3;
    localparam logic [4:0] ADDR_XSTAT = 5'd15;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_RSVD = 2'd3
    } speed_t;

    // stored control fields (the reset bit lives in the timer)
    typedef struct packed {
        logic loop_en;
        logic spd_lo;
        logic neg_en;
        logic pwr_dn;
        logic iso_en;
        logic neg_kick;
        logic fdx;
        logic col_tst;
        logic spd_hi;
        logic uni_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c = '0;
        c.neg_en = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
        ctrl_t c;
        c.loop_en  = w[14];
        c.spd_lo   = w[13];
        c.neg_en   = w[12];
        c.pwr_dn   = w[11];
        c.iso_en   = w[10];
        c.neg_kick = w[9] & w[12];
        c.fdx      = w[8];
        c.col_tst  = w[7];
        c.spd_hi   = w[6];
        c.uni_en   = w[5];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_to_word(input ctrl_t c, input logic busy);
        return {busy, c.loop_en, c.spd_lo, c.neg_en, c.pwr_dn, c.iso_en,
                c.neg_kick, c.fdx, c.col_tst, c.spd_hi, c.uni_en, 5'b00000};
    endfunction

endpackage

// File: rtl/phy_rst_timer.sv
module phy_rst_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.run;
    assign done = tmr_q.run && (tmr_q.cnt == '0);
endmodule

// File: rtl/phy_mode_decode.sv
module phy_mode_decode
    import phy_mgmt_pkg::*;
(
    input  ctrl_t        ctrl,
    input  speed_t       speed_cur,
    input  logic         link_up,
    input  logic [1:0]   an_speed,
    input  logic         an_full_duplex,
    output speed_t       speed_next,
    output logic         full_duplex,
    output logic         tx_allow
);
    logic [1:0] forced_code;
    logic [1:0] pick_code;
    logic       uni_live;

    assign forced_code = {ctrl.spd_hi, ctrl.spd_lo};
    assign pick_code   = ctrl.neg_en ? an_speed : forced_code;

    always_comb begin
        if (pick_code == SPD_RSVD) speed_next = speed_cur;
        else                       speed_next = speed_t'(pick_code);
    end

    assign full_duplex = ctrl.neg_en ? an_full_duplex : ctrl.fdx;
    assign uni_live    = !ctrl.neg_en && ctrl.fdx && ctrl.uni_en;
    assign tx_allow    = !ctrl.pwr_dn && (link_up || uni_live);
endmodule

// File: rtl/phy_loop_path.sv
module phy_loop_path #(
    parameter int unsigned DW = 8
) (
    input  logic          loop_en,
    input  logic          pwr_dn,
    input  logic          tx_allow,
    input  logic [DW-1:0] mac_txd,
    input  logic          mac_tx_en,
    input  logic [DW-1:0] line_rxd,
    input  logic          line_rx_dv,
    output logic [DW-1:0] line_txd,
    output logic          line_tx_en,
    output logic [DW-1:0] mac_rxd,
    output logic          mac_rx_dv
);
    always_comb begin
        line_txd   = '0;
        line_tx_en = 1'b0;
        mac_rxd    = '0;
        mac_rx_dv  = 1'b0;
        if (!pwr_dn) begin
            if (loop_en) begin
                mac_rxd   = mac_txd;
                mac_rx_dv = mac_tx_en;
            end else begin
                line_txd   = mac_txd;
                line_tx_en = mac_tx_en && tx_allow;
                mac_rxd    = line_rxd;
                mac_rx_dv  = line_rx_dv;
            end
        end
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned RST_CYCLES  = 64,
    parameter logic [31:0] PHY_ID      = 32'h0A5C_3E71,
    parameter logic [6:0]  CAPS        = 7'b0111100,
    parameter logic [3:0]  GIG_CAPS    = 4'b0011,
    parameter logic        UNIDIR_ABLE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    reg_addr,
    input  logic [15:0]   wr_data,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [15:0]   rd_data,
    input  logic          link_up,
    input  logic          an_done,
    input  logic [1:0]    an_speed,
    input  logic          an_full_duplex,
    input  logic [DW-1:0] mac_txd,
    input  logic          mac_tx_en,
    input  logic [DW-1:0] line_rxd,
    input  logic          line_rx_dv,
    output logic [DW-1:0] line_txd,
    output logic          line_tx_en,
    output logic [DW-1:0] mac_rxd,
    output logic          mac_rx_dv,
    output logic [1:0]    speed_mode,
    output logic          full_duplex,
    output logic          loopback,
    output logic          power_down,
    output logic          isolate,
    output logic          an_restart,
    output logic          tx_allow
);
    typedef struct packed {
        ctrl_t  ctrl;
        speed_t speed;
        logic   link_drop;
    } state_t;

    state_t st_d, st_q;

    logic   busy, done, ctrl_wr, rst_start;
    speed_t speed_next;
    logic   unused_rsvd;

    assign unused_rsvd = ^wr_data[4:0];

    assign ctrl_wr   = wr_en && (reg_addr == ADDR_CTRL) && !busy;
    assign rst_start = ctrl_wr && wr_data[15];

    phy_rst_timer #(.CYCLES(RST_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (busy),
        .done  (done)
    );

    phy_mode_decode decode_i (
        .ctrl           (st_q.ctrl),
        .speed_cur      (st_q.speed),
        .link_up        (link_up),
        .an_speed       (an_speed),
        .an_full_duplex (an_full_duplex),
        .speed_next     (speed_next),
        .full_duplex    (full_duplex),
        .tx_allow       (tx_allow)
    );

    phy_loop_path #(.DW(DW)) path_i (
        .loop_en    (st_q.ctrl.loop_en),
        .pwr_dn     (st_q.ctrl.pwr_dn),
        .tx_allow   (tx_allow),
        .mac_txd    (mac_txd),
        .mac_tx_en  (mac_tx_en),
        .line_rxd   (line_rxd),
        .line_rx_dv (line_rx_dv),
        .line_txd   (line_txd),
        .line_tx_en (line_tx_en),
        .mac_rxd    (mac_rxd),
        .mac_rx_dv  (mac_rx_dv)
    );

    always_comb begin
        st_d = st_q;
        st_d.ctrl.neg_kick = 1'b0;
        st_d.speed = speed_next;

        if (done) begin
            st_d.ctrl  = ctrl_default();
            st_d.speed = SPD_10;
        end else if (ctrl_wr && !wr_data[15]) begin
            st_d.ctrl = ctrl_from_word(wr_data);
        end

        if (!link_up)
            st_d.link_drop = 1'b1;
        else if (done || (rd_en && reg_addr == ADDR_STAT))
            st_d.link_drop = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl      <= ctrl_default();
            st_q.speed     <= SPD_10;
            st_q.link_drop <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  rd_data = ctrl_to_word(st_q.ctrl, busy);
            ADDR_STAT:  rd_data = {CAPS, 1'b1, UNIDIR_ABLE, 1'b0,
                                   an_done & st_q.ctrl.neg_en, 1'b0, 1'b1,
                                   link_up & ~st_q.link_drop, 1'b0, 1'b1};
            ADDR_ID_HI: rd_data = PHY_ID[31:16];
            ADDR_ID_LO: rd_data = PHY_ID[15:0];
            ADDR_XSTAT: rd_data = {GIG_CAPS, 12'h000};
            default:    rd_data = 16'h0000;
        endcase
    end

    assign speed_mode = st_q.speed;
    assign loopback   = st_q.ctrl.loop_en;
    assign power_down = st_q.ctrl.pwr_dn;
    assign isolate    = st_q.ctrl.iso_en;
    assign an_restart = st_q.ctrl.neg_kick;
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  reg_addr,
    input logic [15:0] rd_data,
    input logic        an_restart,
    input logic        power_down,
    input logic        loopback,
    input logic        line_tx_en,
    input logic        mac_rx_dv,
    input logic        tx_allow
);
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd0) |-> (rd_data[4:0] == 5'd0));

    assert_xstat_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd15) |-> (rd_data[11:0] == 12'd0));

    assert_unimpl_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 5'd3 && reg_addr != 5'd15) |-> (rd_data == 16'd0));

    assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> !an_restart);

    assert_pdn_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (!line_tx_en && !mac_rx_dv && !tx_allow));

    assert_loop_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |-> !line_tx_en);
endmodule

bind phy_mgmt_regs phy_mgmt_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .rd_data    (rd_data),
    .an_restart (an_restart),
    .power_down (power_down),
    .loopback   (loopback),
    .line_tx_en (line_tx_en),
    .mac_rx_dv  (mac_rx_dv),
    .tx_allow   (tx_allow)
);

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
    localparam int RSTC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        link_up = 1'b0, an_done = 1'b0, an_full_duplex = 1'b0;
    logic [1:0]  an_speed = 2'd0;
    logic [7:0]  mac_txd = 8'h00, line_rxd = 8'h00;
    logic        mac_tx_en = 1'b0, line_rx_dv = 1'b0;
    logic [7:0]  line_txd, mac_rxd;
    logic        line_tx_en, mac_rx_dv;
    logic [1:0]  speed_mode;
    logic        full_duplex, loopback, power_down, isolate, an_restart, tx_allow;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    phy_mgmt_regs #(.RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .link_up(link_up),
        .an_done(an_done), .an_speed(an_speed), .an_full_duplex(an_full_duplex),
        .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .line_rxd(line_rxd),
        .line_rx_dv(line_rx_dv), .line_txd(line_txd), .line_tx_en(line_tx_en),
        .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv), .speed_mode(speed_mode),
        .full_duplex(full_duplex), .loopback(loopback), .power_down(power_down),
        .isolate(isolate), .an_restart(an_restart), .tx_allow(tx_allow)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        rd(5'd0, v);
        check(v, 16'h1000, "R1 control default");
        check(speed_mode, 0, "R1 speed default");
        check(full_duplex, 0, "R1 duplex default");
        check(an_restart, 0, "R1 restart idle");
    endtask

    task automatic t_ids_unimpl();
        logic [15:0] v;
        rd(5'd2, v); check(v, 16'h0A5C, "R11 id high");
        rd(5'd3, v); check(v, 16'h3E71, "R11 id low");
        rd(5'd15, v); check(v, 16'h3000, "R11 ext status");
        rd(5'd4, v); check(v, 16'h0000, "R13 addr 4");
        rd(5'd31, v); check(v, 16'h0000, "R13 addr 31");
    endtask

    task automatic t_status_latch();
        logic [15:0] v;
        link_up = 1'b1; an_done = 1'b1;
        rd(5'd1, v);
        rd(5'd1, v); check(v, 16'h79AD, "R10 status word");
        @(negedge clk) link_up = 1'b0;
        @(negedge clk) link_up = 1'b1;
        rd(5'd1, v); check(v, 16'h79A9, "R12 latched low after drop");
        rd(5'd1, v); check(v, 16'h79AD, "R12 follows link after read");
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(5'd0, 16'h101F);
        rd(5'd0, v); check(v, 16'h1000, "R9 reserved bits read zero");
    endtask

    task automatic t_speed();
        wr(5'd0, 16'h0000); @(negedge clk);
        check(speed_mode, 0, "R4 forced 10"); check(full_duplex, 0, "R4 half");
        wr(5'd0, 16'h2100); @(negedge clk);
        check(speed_mode, 1, "R4 forced 100"); check(full_duplex, 1, "R4 full");
        wr(5'd0, 16'h0040); @(negedge clk);
        check(speed_mode, 2, "R4 forced 1000");
        wr(5'd0, 16'h2040); @(negedge clk);
        check(speed_mode, 2, "R4 reserved code keeps speed");
        an_speed = 2'd1; an_full_duplex = 1'b1;
        wr(5'd0, 16'h1000); @(negedge clk);
        check(speed_mode, 1, "R4 negotiated speed"); check(full_duplex, 1, "R4 negotiated duplex");
        an_speed = 2'd3; repeat (2) @(negedge clk);
        check(speed_mode, 1, "R4 negotiated reserved keeps speed");
        an_speed = 2'd0; an_full_duplex = 1'b0;
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(5'd0, 16'h1200);
        check(an_restart, 1, "R5 restart pulse");
        rd(5'd0, v);
        check(v, 16'h1000, "R5 bit clears itself");
        check(an_restart, 0, "R5 pulse one cycle");
        wr(5'd0, 16'h0200);
        check(an_restart, 0, "R5 no restart without neg enable");
        rd(5'd0, v); check(v, 16'h0000, "R5 bit stays zero");
    endtask

    task automatic t_unidir();
        link_up = 1'b0;
        wr(5'd0, 16'h0120); check(tx_allow, 1, "R6 unidir in effect");
        wr(5'd0, 16'h0020); check(tx_allow, 0, "R6 unidir gated by half duplex");
        wr(5'd0, 16'h1120); check(tx_allow, 0, "R6 unidir gated by negotiation");
        wr(5'd0, 16'h0100); check(tx_allow, 0, "R6 no link no unidir");
        link_up = 1'b1; #1 check(tx_allow, 1, "R6 link up allows");
    endtask

    task automatic t_datapath();
        mac_txd = 8'hA5; mac_tx_en = 1'b1; line_rxd = 8'h3C; line_rx_dv = 1'b1;
        wr(5'd0, 16'h1000);
        check({line_txd, line_tx_en, mac_rxd, mac_rx_dv}, {8'hA5, 1'b1, 8'h3C, 1'b1}, "R7 normal path");
        wr(5'd0, 16'h5000);
        check({line_txd, line_tx_en, mac_rxd, mac_rx_dv}, {8'h00, 1'b0, 8'hA5, 1'b1}, "R7 loopback path");
        wr(5'd0, 16'h1800);
        check({line_txd, line_tx_en, mac_rxd, mac_rx_dv, tx_allow}, 0, "R8 power down silent");
        check(power_down, 1, "R8 power down output");
        wr(5'd0, 16'h1400);
        check(isolate, 1, "R8 isolate output");
        wr(5'd0, 16'h1000);
        check(isolate, 0, "R8 isolate cleared");
        mac_tx_en = 1'b0; line_rx_dv = 1'b0;
    endtask

    task automatic t_soft_reset();
        logic [15:0] v;
        wr(5'd0, 16'h0140);
        wr(5'd0, 16'h9000);
        rd(5'd0, v); check(v, 16'h8140, "R2 busy reads bit15 and keeps fields");
        wr(5'd0, 16'h4100);
        rd(5'd0, v); check(v, 16'h8140, "R3 write discarded during reset");
        repeat (RSTC + 2) @(negedge clk);
        rd(5'd0, v); check(v, 16'h1000, "R2 defaults after reset");
        check(speed_mode, 0, "R2 speed default after reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ids_unimpl();
        t_status_latch();
        t_reserved();
        t_speed();
        t_restart();
        t_unidir();
        t_datapath();
        t_soft_reset();
        summary();
    end
endmodule